// File: doc/BRIEF.md
# Retry-Aware Bus Arbiter with Grant Lock

This block arbitrates a shared parallel bus among three local masters: a cascaded legacy DMA master (slot 0), a USB-style master (slot 1) and an IDE-style master (slot 2). Before any local master may drive the bus, the block asks an upstream host arbiter for ownership. It raises `hold_req` and waits for `hold_ack`. Grants go out one at a time while the bus is idle. Outside the locked state they rotate round-robin.

The upstream host may answer the legacy master's cycle with a retry, which starts a delayed transaction on the host side. In that case the arbiter gives up its hold request passively, so that another upstream master can use the bus. It also pins its rotation to the legacy slot. The host retries every cycle except the outstanding delayed one, so a USB or IDE grant at this point would only stall that master. The block therefore stays locked until one of three events occurs:

- the legacy cycle completes,
- the host signals that its delayed-transaction timer expired, or
- a local timer with a programmable limit runs out. This path also raises a sticky error flag.

Top module: `retry_lock_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. Bit 0 is the legacy DMA slot, bit 1 the USB slot and bit 2 the IDE slot.
- R2: Outside the lock, the grant goes to the first requesting slot found by scanning upward, with wrap, from a rotation pointer. The pointer moves to the slot after the owner only when the owner's cycle completes without retry.
- R3: A new grant appears one clock after a cycle that meets all four conditions: `hold_ack` high, `frame_busy` low, no grant held, and no release pending.
- R4: When the legacy slot's cycle is retried, its grant drops on the next clock. `hold_req` then stays low until `hold_ack` has been seen low (passive release).
- R5: While `locked` is high, USB and IDE requests are ignored and only the legacy slot can be granted.
- R6: A non-retried completion of a legacy cycle clears the lock.
- R7: The lock clears after `tmo_limit` clocks spent locked with no grant held, where a limit of 0 acts as 1. Such a timeout sets `tmo_err`, which stays set until reset.
- R8: `host_dt_expired` clears the lock at the next clock without setting `tmo_err`.
- R9: A retried USB or IDE cycle releases its grant. It neither locks the arbiter nor advances the pointer.
- R10: A synchronous active-low reset clears the grants, the lock, the release state and `tmo_err`, and points the rotation at the legacy slot.
- R11: A grant holds until `cyc_done` or `cyc_retry` arrives. When both arrive together, the retry takes precedence.
- R12: `hold_req` is high when either of these is true:
  - a grant is held, or
  - some request allowed by the lock state is pending and no passive release is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_REQ | Local bus requests, one per slot |
| hold_ack | input | 1 | Upstream host grants the bus to this block |
| frame_busy | input | 1 | A bus cycle is in progress |
| cyc_done | input | 1 | Owner's cycle ended successfully |
| cyc_retry | input | 1 | Owner's cycle was answered with a retry |
| host_dt_expired | input | 1 | Host discarded its delayed transaction |
| tmo_limit | input | TMO_W | Local lock timeout in clocks |
| gnt | output | N_REQ | One-hot local grant |
| hold_req | output | 1 | Ownership request to the host arbiter |
| locked | output | 1 | Rotation pinned to the legacy slot |
| tmo_err | output | 1 | Sticky local-timeout flag |

## Verification
The hardest state to reach from the ports is a lock that survives long enough to observe the starvation rule and the local timeout. A lock like this needs several things at once:
- the legacy master has been granted and then retried;
- the host has dropped `hold_ack` to finish the passive release;
- the legacy request has been withdrawn while the other two slots keep requesting.

Directed sequences build exactly that order and count the clocks to the timeout edge. A long pseudo-random phase then mixes retries, completions, expiry pulses and acknowledge gaps. It is compared every clock against a behavioural model kept in integers.

// File: rtl/retry_arb_pkg.sv
package retry_arb_pkg;
  localparam int ARB_REQS    = 3;
  localparam int LEGACY_SLOT = 0;

  // slot after idx, wrapping at n
  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // a zero timeout limit behaves as one clock
  function automatic int limit_floor(input int lim);
    return (lim < 1) ? 1 : lim;
  endfunction
endpackage

// File: rtl/arb_rr_picker.sv
module arb_rr_picker #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  pick
);
  // first set bit at or above start, with wrap; lowest offset wins
  function automatic logic [N-1:0] scan_from(input logic [N-1:0] r, input int start);
    logic [N-1:0] g;
    g = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (r[(start + k) % N]) begin
        g = '0;
        g[(start + k) % N] = 1'b1;
      end
    end
    return g;
  endfunction

  assign pick = scan_from(req, int'(ptr));
endmodule

// File: rtl/arb_lock_timer.sv
module arb_lock_timer import retry_arb_pkg::*; #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_nx;
  logic [TW:0]   lim_eff;

  assign lim_eff = (TW+1)'(limit_floor(int'(limit)));
  assign cnt_nx  = {1'b0, cnt_q} + (TW+1)'(1);
  assign expire  = run && (cnt_nx >= lim_eff);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) cnt_q <= '0;
    else                       cnt_q <= cnt_nx[TW-1:0];
  end

  // R7
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < lim_eff));
endmodule

// File: rtl/retry_lock_arbiter.sv
module retry_lock_arbiter import retry_arb_pkg::*; #(
  parameter int N_REQ   = ARB_REQS,
  parameter int LEG_IDX = LEGACY_SLOT,
  parameter int TMO_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             hold_ack,
  input  logic             frame_busy,
  input  logic             cyc_done,
  input  logic             cyc_retry,
  input  logic             host_dt_expired,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [N_REQ-1:0] gnt,
  output logic             hold_req,
  output logic             locked,
  output logic             tmo_err
);
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [N_REQ-1:0] LEG_MASK = N_REQ'(1) << LEG_IDX;

  logic [N_REQ-1:0] gnt_q;
  logic [IW-1:0]    ptr_q;
  logic             lock_q, rel_q, err_q;

  // named internal events
  logic             busy_own, retry_ev, done_ev;
  logic             legacy_retry, legacy_done;
  logic             issue, unlock, tmr_run, tmr_expire;
  logic [N_REQ-1:0] elig, pick;
  logic [IW-1:0]    owner_idx;

  function automatic logic [IW-1:0] slot_of(input logic [N_REQ-1:0] oh);
    logic [IW-1:0] s;
    s = '0;
    for (int i = 0; i < N_REQ; i++) if (oh[i]) s = IW'(i);
    return s;
  endfunction

  assign busy_own     = |gnt_q;
  assign retry_ev     = busy_own && cyc_retry;
  assign done_ev      = busy_own && cyc_done && !cyc_retry;
  assign legacy_retry = retry_ev && gnt_q[LEG_IDX];
  assign legacy_done  = done_ev && gnt_q[LEG_IDX];
  assign elig         = lock_q ? (req & LEG_MASK) : req;
  assign issue        = !busy_own && !rel_q && hold_ack && !frame_busy && (|elig);
  assign tmr_run      = lock_q && !busy_own;
  assign unlock       = legacy_done || host_dt_expired || tmr_expire;
  assign owner_idx    = slot_of(gnt_q);

  arb_rr_picker #(.N(N_REQ)) u_pick (
    .req  (elig),
    .ptr  (ptr_q),
    .pick (pick)
  );

  arb_lock_timer #(.TW(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .clr    (legacy_retry),
    .limit  (tmo_limit),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      ptr_q  <= IW'(LEG_IDX);
      lock_q <= 1'b0;
      rel_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (issue)                   gnt_q <= pick;
      else if (retry_ev || done_ev) gnt_q <= '0;

      if (done_ev) ptr_q <= IW'(wrap_next(int'(owner_idx), N_REQ));

      if (legacy_retry)   rel_q <= 1'b1;
      else if (!hold_ack) rel_q <= 1'b0;

      if (legacy_retry) lock_q <= 1'b1;
      else if (unlock)  lock_q <= 1'b0;

      if (tmr_expire) err_q <= 1'b1;
    end
  end

  assign gnt      = gnt_q;
  assign hold_req = busy_own || (!rel_q && (|elig));
  assign locked   = lock_q;
  assign tmo_err  = err_q;

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R3
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_own && !$past(busy_own)) |-> $past(!frame_busy && hold_ack));
  // R4
  passive_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_retry |=> (!hold_req && !busy_own));
  // R5
  lock_only_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> ((gnt_q & ~LEG_MASK) == '0));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8
  host_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dt_expired && !legacy_retry) |=> !lock_q);
  // R11
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_own && !cyc_done && !cyc_retry) |=> $stable(gnt_q));
endmodule

// File: tb/retry_lock_arbiter_test.sv
`timescale 1ns/1ps
module retry_lock_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic       hold_ack = 1'b0, frame_busy = 1'b0, cyc_done = 1'b0, cyc_retry = 1'b0;
  logic       host_dt_expired = 1'b0;
  logic [7:0] tmo_limit = 8'd200;
  logic [2:0] gnt;
  logic       hold_req, locked, tmo_err;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  retry_lock_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .hold_ack(hold_ack),
    .frame_busy(frame_busy), .cyc_done(cyc_done), .cyc_retry(cyc_retry),
    .host_dt_expired(host_dt_expired), .tmo_limit(tmo_limit),
    .gnt(gnt), .hold_req(hold_req), .locked(locked), .tmo_err(tmo_err)
  );

  // behavioural reference: owner as an integer slot, -1 when none
  int m_owner = -1, m_ptr = 0, m_cnt = 0;
  bit m_lock = 0, m_rel = 0, m_err = 0;

  function automatic int allowed_reqs();
    return m_lock ? (int'(req) & 1) : int'(req);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = -1; m_ptr = 0; m_cnt = 0; m_lock = 0; m_rel = 0; m_err = 0;
    end else begin
      bit busy, rty, dn, legr, iss, tmo;
      int el, nxt, lim;
      busy = (m_owner >= 0);
      rty  = busy && cyc_retry;
      dn   = busy && cyc_done && !cyc_retry;
      legr = rty && (m_owner == 0);
      el   = allowed_reqs();
      iss  = !busy && !m_rel && hold_ack && !frame_busy && (el != 0);
      lim  = (tmo_limit == 0) ? 1 : int'(tmo_limit);
      tmo  = m_lock && !busy && (m_cnt + 1 >= lim);
      nxt  = m_owner;
      if (iss) begin
        for (int k = 2; k >= 0; k--)
          if (((el >> ((m_ptr + k) % 3)) & 1) != 0) nxt = (m_ptr + k) % 3;
      end else if (rty || dn) nxt = -1;
      if (dn) m_ptr = (m_owner + 1) % 3;
      if (legr || !(m_lock && !busy)) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (legr) m_rel = 1; else if (!hold_ack) m_rel = 0;
      if (legr) m_lock = 1;
      else if ((dn && m_owner == 0) || host_dt_expired || tmo) m_lock = 0;
      if (tmo) m_err = 1;
      m_owner = nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    int eg, eh;
    @(negedge clk);
    eg = (m_owner < 0) ? 0 : (1 << m_owner);
    eh = ((m_owner >= 0) || (!m_rel && allowed_reqs() != 0)) ? 1 : 0;
    chk("R1/R2 gnt vs model", int'(gnt), eg);
    chk("R12 hold_req vs model", int'(hold_req), eh);
    chk("R5 locked vs model", int'(locked), int'(m_lock));
    chk("R7 tmo_err vs model", int'(tmo_err), int'(m_err));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R10 reset state
    chk("R10 gnt after reset", int'(gnt), 0);
    chk("R10 hold_req after reset", int'(hold_req), 0);
    chk("R10 locked after reset", int'(locked), 0);
    chk("R10 tmo_err after reset", int'(tmo_err), 0);
    rst_n = 1'b1;

    // R2 rotation from the legacy slot
    req = 3'b111; hold_ack = 1'b1;
    tick(); chk("R2 first grant legacy", int'(gnt), 1);
    cyc_done = 1'b1; tick(); chk("R11 grant drops on done", int'(gnt), 0);
    cyc_done = 1'b0; tick(); chk("R2 rotate to USB", int'(gnt), 2);
    cyc_done = 1'b1; tick(); cyc_done = 1'b0; tick();
    chk("R2 rotate to IDE", int'(gnt), 4);
    cyc_done = 1'b1; tick(); cyc_done = 1'b0; tick();
    chk("R2 wrap to legacy", int'(gnt), 1);

    // R4/R5/R6 retry lock
    cyc_retry = 1'b1; tick();
    chk("R4 grant dropped on legacy retry", int'(gnt), 0);
    chk("R4 hold_req released", int'(hold_req), 0);
    chk("R5 locked after retry", int'(locked), 1);
    cyc_retry = 1'b0; tick();
    chk("R4 hold_req low while ack high", int'(hold_req), 0);
    chk("R5 no grant to USB/IDE", int'(gnt), 0);
    hold_ack = 1'b0; tick();
    chk("R12 hold_req back after release", int'(hold_req), 1);
    req = 3'b110; hold_ack = 1'b1; tick();
    chk("R5 others ignored while locked", int'(gnt), 0);
    chk("R5 hold_req low with only others", int'(hold_req), 0);
    req = 3'b111; tick();
    chk("R5 legacy regranted", int'(gnt), 1);
    cyc_done = 1'b1; tick();
    chk("R6 lock cleared on legacy done", int'(locked), 0);
    cyc_done = 1'b0; tick();
    chk("R6 rotation resumes at USB", int'(gnt), 2);
    cyc_done = 1'b1; tick(); cyc_done = 1'b0;

    // R8 host expiry
    req = 3'b001; tick();
    chk("R2 scan wraps to legacy", int'(gnt), 1);
    cyc_retry = 1'b1; tick(); cyc_retry = 1'b0;
    chk("R5 locked again", int'(locked), 1);
    host_dt_expired = 1'b1; tick(); host_dt_expired = 1'b0;
    chk("R8 host expiry unlocks", int'(locked), 0);
    chk("R8 no error on host expiry", int'(tmo_err), 0);
    hold_ack = 1'b0; tick(); hold_ack = 1'b1;

    // R7 local timeout, limit 5
    tmo_limit = 8'd5;
    tick();
    chk("R7 legacy granted before timeout test", int'(gnt), 1);
    cyc_retry = 1'b1; tick(); cyc_retry = 1'b0;
    req = 3'b110; hold_ack = 1'b0;
    repeat (4) tick();
    chk("R7 still locked before limit", int'(locked), 1);
    chk("R7 no error before limit", int'(tmo_err), 0);
    tick();
    chk("R7 lock cleared at limit", int'(locked), 0);
    chk("R7 error set at limit", int'(tmo_err), 1);
    hold_ack = 1'b1; tick();
    chk("R7 IDE served after timeout", int'(gnt), 4);

    // R9 USB retry
    cyc_done = 1'b1; tick(); cyc_done = 1'b0;
    tick();
    chk("R9 USB granted", int'(gnt), 2);
    cyc_retry = 1'b1; cyc_done = 1'b1; tick();
    cyc_retry = 1'b0; cyc_done = 1'b0;
    chk("R9 USB retry releases grant", int'(gnt), 0);
    chk("R9 USB retry does not lock", int'(locked), 0);
    chk("R11 retry wins over done", int'(hold_req), 1);
    frame_busy = 1'b1; tick();
    chk("R3 no grant while frame busy", int'(gnt), 0);
    frame_busy = 1'b0; tick();
    chk("R9 pointer not advanced", int'(gnt), 2);
    chk("R7 error sticky", int'(tmo_err), 1);

    // random phase, limit changed only under reset
    for (int i = 0; i < 6000; i++) begin
      if (i % 800 == 0) begin
        rst_n = 1'b0; tmo_limit = 8'($urandom % 6);
      end else rst_n = 1'b1;
      req             = 3'($urandom % 8);
      hold_ack        = ($urandom % 4) != 0;
      frame_busy      = ($urandom % 3) == 0;
      cyc_done        = ($urandom % 4) == 0;
      cyc_retry       = ($urandom % 6) == 0;
      host_dt_expired = ($urandom % 40) == 0;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule